// File: doc/BRIEF.md
# Vector Halving Reduction Sequencer

This block adds up every active element of one vector register and returns the total as a single scalar. A start pulse loads the register contents and a starting vector length. The sequencer does not use an adder tree. It runs a loop. In each pass it copies the upper part of the active elements into a scratch vector. It then adds that scratch vector lane by lane onto the lower part, and the active length shrinks to about half. When only one element is left, that element is the sum. The result is returned with a one-cycle done strobe.

Only one restricted permutation is used: take the upper part of the active elements and shift it down. No general permutation network is built. The only arithmetic is a plain lane-wise adder. Every addition wraps modulo the element width.

Top module: `vec_halving_reducer`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` read 0 and `result` reads 0.
- R2: A `start` in a cycle where `busy` is 0 loads `src_vec` and `src_vl`, and `busy` reads 1 from the next cycle. Element i of `src_vec` sits at bits [i*EW +: EW].
- R3: A pass with active length L moves the elements at indices ceil(L/2) to L-1 down to lanes 0 to floor(L/2)-1 of a scratch vector. The pass then adds the scratch vector onto those lower lanes, and the active length becomes ceil(L/2). Each pass takes two cycles.
- R4: When L is odd, the element at index ceil(L/2)-1 has no partner. It goes into the next pass unchanged.
- R5: Lanes at index floor(L/2) and above are not written by an add pass.
- R6: `result` equals the sum, modulo 2^EW, of elements 0 to L0-1, where L0 is the clamped start length. `done` is high for exactly one cycle, 1+2k cycles after the start edge, where k = ceil(log2 L0). `result` holds its value until the next `done`.
- R7: A start with length 0 returns 0 after 1 cycle. A start with length 1 returns element 0 after 1 cycle, with no add pass.
- R8: A `start` while `busy` is 1 has no effect on the running reduction or on its result.
- R9: A `src_vl` above MVL is treated as MVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction (taken only when idle) |
| src_vec | input | MVL*EW | Source vector, element i at bits [i*EW +: EW] |
| src_vl | input | $clog2(MVL+1) | Starting active length |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | EW | Wrapped sum of the active elements |

## Verification
The reduction is tried with every length from 0 to MVL. Even and odd lengths separate a correct carry of the unpaired element from one that drops it or adds it twice. Lengths that are not a power of two check the pass count, which shows up in when `done` rises. All-ones data checks the wrap modulo 2^EW. Lengths above MVL check the clamp. Index-weighted data exposes any lane that is read from the wrong place. A second start during a run must leave the result of the first run unchanged. A start in the same cycle as `done` must be taken, which checks back-to-back operation.

// File: rtl/vhr_pkg.sv
package vhr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MOVE = 2'd1,
      ST_ADD  = 2'd2
   } vhr_state_t;
endpackage

// File: rtl/vhr_half_mover.sv
// Restricted permutation: shift the upper part of the active elements down
// to lane 0. Lanes that receive no element read zero.
module vhr_half_mover #(
   parameter int EW  = 16,
   parameter int MVL = 8,
   parameter int LW  = $clog2(MVL + 1)
) (
   input  logic [MVL-1:0][EW-1:0] vin,
   input  logic [LW-1:0]          vl,
   output logic [MVL-1:0][EW-1:0] upper,
   output logic [LW-1:0]          half,
   output logic [LW-1:0]          keep
);
   assign half = vl >> 1;
   assign keep = vl - half;

   for (genvar i = 0; i < MVL; i++) begin : g_lane
      logic [EW-1:0] lane_val;
      always_comb begin
         lane_val = '0;
         if (LW'(i) < half) begin
            for (int k = 1; k < MVL - i; k++) begin
               if (keep == LW'(k)) lane_val = vin[i + k];
            end
         end
      end
      assign upper[i] = lane_val;
   end
endmodule

// File: rtl/vhr_lane_adder.sv
// Element-wise adder: lanes below 'half' add, the rest pass through.
module vhr_lane_adder #(
   parameter int EW  = 16,
   parameter int MVL = 8,
   parameter int LW  = $clog2(MVL + 1)
) (
   input  logic [MVL-1:0][EW-1:0] a,
   input  logic [MVL-1:0][EW-1:0] b,
   input  logic [LW-1:0]          half,
   output logic [MVL-1:0][EW-1:0] sum
);
   for (genvar i = 0; i < MVL; i++) begin : g_add
      assign sum[i] = (LW'(i) < half) ? EW'(a[i] + b[i]) : a[i];
   end
endmodule

// File: rtl/vec_halving_reducer.sv
module vec_halving_reducer
   import vhr_pkg::*;
#(
   parameter int EW  = 16,
   parameter int MVL = 8,
   parameter int LW  = $clog2(MVL + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MVL*EW-1:0]   src_vec,
   input  logic [LW-1:0]       src_vl,
   output logic                busy,
   output logic                done,
   output logic [EW-1:0]       result
);
   if (MVL < 2) begin : g_chk_mvl
      $error("vec_halving_reducer: MVL must be at least 2");
   end
   if (EW < 1) begin : g_chk_ew
      $error("vec_halving_reducer: EW must be at least 1");
   end
   if ((1 << LW) <= MVL) begin : g_chk_lw
      $error("vec_halving_reducer: LW too narrow for MVL");
   end

   localparam logic [LW-1:0] VL_MAX = LW'(MVL);

   vhr_state_t             state;
   logic [LW-1:0]          vl_q;
   logic [MVL-1:0][EW-1:0] vreg;
   logic [MVL-1:0][EW-1:0] tmp;
   logic [EW-1:0]          res_q;
   logic                   done_q;

   logic [MVL-1:0][EW-1:0] upper, summed;
   logic [LW-1:0]          half, keep;
   logic [LW-1:0]          vl_in;

   assign vl_in = (src_vl > VL_MAX) ? VL_MAX : src_vl;

   vhr_half_mover #(.EW(EW), .MVL(MVL), .LW(LW)) u_mover (
      .vin   (vreg),
      .vl    (vl_q),
      .upper (upper),
      .half  (half),
      .keep  (keep)
   );

   vhr_lane_adder #(.EW(EW), .MVL(MVL), .LW(LW)) u_adder (
      .a    (vreg),
      .b    (tmp),
      .half (half),
      .sum  (summed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         vl_q   <= '0;
         vreg   <= '0;
         tmp    <= '0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  vreg  <= src_vec;
                  vl_q  <= vl_in;
                  state <= ST_MOVE;
               end
            end
            ST_MOVE: begin
               if (vl_q <= LW'(1)) begin
                  res_q  <= (vl_q == '0) ? '0 : vreg[0];
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  tmp   <= upper;
                  state <= ST_ADD;
               end
            end
            ST_ADD: begin
               vreg  <= summed;
               vl_q  <= keep;
               state <= ST_MOVE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign done   = done_q;
   assign result = res_q;

   // R6: done is a single-cycle strobe
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: done only follows a busy cycle
   a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R3: every add pass leaves the active length at ceil(L/2)
   a_r3_vl_halves: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADD) |=> (vl_q == (($past(vl_q) >> 1) + ($past(vl_q) & LW'(1)))));
   // R8: while busy nothing reloads the length, so it never grows
   a_r8_vl_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (vl_q <= $past(vl_q)));
   // R5: the top lane is never an add lane, so it only changes on load
   a_r5_top_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(vreg[MVL-1]));
endmodule

// File: tb/vec_halving_reducer_test.sv
module vec_halving_reducer_test;
   localparam int EW  = 16;
   localparam int MVL = 8;
   localparam int LW  = $clog2(MVL + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [MVL*EW-1:0] src_vec = '0;
   logic [LW-1:0]     src_vl = '0;
   logic              busy, done;
   logic [EW-1:0]     result;

   always #2 clk = ~clk;

   vec_halving_reducer #(.EW(EW), .MVL(MVL), .LW(LW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_vec(src_vec),
      .src_vl(src_vl), .busy(busy), .done(done), .result(result)
   );

   int checks = 0;
   int bad = 0;
   string tag = "R1";

   // behavioural reference model
   bit            m_busy = 0, m_done = 0;
   int            m_cnt = 0;
   logic [EW-1:0] m_res = '0, m_pend = '0;
   int            cycles = 0;

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0; m_done = 1; m_res = m_pend;
            end
         end else if (start) begin
            int l, k;
            l = (int'(src_vl) > MVL) ? MVL : int'(src_vl);
            m_pend = '0;
            for (int i = 0; i < l; i++) m_pend = m_pend + src_vec[i*EW +: EW];
            k = 0;
            while ((1 << k) < l) k++;
            m_cnt = 1 + 2 * k;
            m_busy = 1;
         end
      end
   end

   task automatic chk(input string what, input logic [EW-1:0] act, input logic [EW-1:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      chk("busy", EW'(busy), EW'(m_busy));
      chk("done", EW'(done), EW'(m_done));
      chk("result", result, m_res);
   end

   task automatic launch(input logic [MVL*EW-1:0] v, input int l);
      @(negedge clk);
      while (busy) @(negedge clk);
      start = 1'b1; src_vec = v; src_vl = LW'(l);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (!done && cycles < 100000) @(negedge clk);
   endtask

   function automatic logic [MVL*EW-1:0] ramp(input int base, input int step);
      logic [MVL*EW-1:0] v;
      for (int i = 0; i < MVL; i++) v[i*EW +: EW] = EW'(base + step * i * i + i);
      return v;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      chk("reset result", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R6: every length with index-weighted data
      for (int l = 2; l <= MVL; l++) begin
         tag = (l % 2) ? "R4" : "R3";
         launch(ramp(3 * l, 7), l);
         tag = "R2";
         chk("busy after start", EW'(busy), 1'b1);
         tag = (l % 2) ? "R4" : "R6";
         wait_done();
         @(negedge clk);
      end

      tag = "R7";
      launch(ramp(100, 1), 0);
      wait_done(); @(negedge clk);
      chk("zero length", result, '0);
      launch(ramp(55, 2), 1);
      wait_done(); @(negedge clk);
      chk("one element", result, EW'(55));

      tag = "R6";  // wrap: all ones across every lane
      launch('1, MVL);
      wait_done(); @(negedge clk);
      chk("wrap sum", result, EW'(-MVL));

      tag = "R9";
      launch(ramp(9, 5), (1 << LW) - 1);
      wait_done(); @(negedge clk);
      launch(ramp(1, 11), MVL + 1);
      wait_done(); @(negedge clk);

      tag = "R8";  // second start mid-run must not disturb the first
      launch(ramp(20, 3), MVL);
      @(negedge clk);
      start = 1'b1; src_vec = ramp(999, 13); src_vl = LW'(3);
      @(negedge clk);
      start = 1'b0;
      wait_done(); @(negedge clk);
      begin
         logic [EW-1:0] s;
         logic [MVL*EW-1:0] v;
         v = ramp(20, 3);
         s = '0;
         for (int i = 0; i < MVL; i++) s = s + v[i*EW +: EW];
         chk("ignored start", result, s);
      end

      tag = "R5";  // back-to-back: start in the done cycle, odd length
      launch(ramp(4, 9), 5);
      wait_done();
      start = 1'b1; src_vec = ramp(60, 1); src_vl = LW'(7);
      @(negedge clk);
      start = 1'b0;
      wait_done(); @(negedge clk);

      if (cycles >= 100000) begin
         checks++; bad++;
         $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      end
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #1000000;
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule